// File: doc/BRIEF.md
# Sixteen-bit ALU with Accumulator Pair and Status Flags

This block is the arithmetic stage of a small multicycle processor datapath. Each cycle it picks a first operand from the A register, the memory data register or the program counter. It picks a second operand from the B register, the memory data register, the constant two or the low nine instruction bits. It then applies one of eight operations chosen by a 3-bit code. Results that fit in one word appear combinationally on `result`. A signed multiply or divide instead loads a dedicated high/low accumulator pair when the controller issues it.

An 8-bit status register collects carry, overflow, negative, zero, less-than and interrupt-enable. The arithmetic flags change only when the controller asserts a flag-write strobe. The interrupt-enable bit has its own set and clear inputs. A compare mode runs a subtraction purely to update the flags and asks for no register write. The branch output evaluates one of four conditions against the registered zero and less-than flags, so the sequencer can decide a branch in the cycle after a compare.

Top module: `alu16_mc`

## Requirements
- R1: `op_code` selects the operation on the two operands: 0 add, 1 subtract (first minus second), 2 AND, 3 OR, 4 NOR, 5 signed set-on-less-than (result 1 or 0). For these codes, when `issue` is high and `cmp_mode` is low, `result_we` is 1.
- R2: `sel_a` picks the first operand: 0 the A register, 1 the memory data register, 2 the PC, 3 the value zero.
- R3: `sel_b` picks the second operand: 0 the B register, 1 the memory data register, 2 the constant 2, 3 `ir_imm` zero-extended to 16 bits.
- R4: Code 6 forms the 32-bit signed product. When `issue` is high, the clock edge loads the upper half into `acc_hi` and the lower half into `acc_lo`. `result` shows the lower half and `result_we` is 0.
- R5: Code 7 forms the signed quotient, truncated toward zero, and the remainder, which takes the dividend's sign. When `issue` is high, the quotient goes to `acc_lo` and the remainder to `acc_hi`, and `result_we` is 0. With a zero divisor the accumulators keep their values and `result` is 0.
- R6: The accumulators change only on an edge where `issue` is high, the code is 6 or 7, `cmp_mode` is low and the divide (if any) has a non-zero divisor.
- R7: On an edge with `flag_we` high, the status bits load as follows. Bit 0 carry: carry-out for add, unsigned borrow for subtract, 0 otherwise. Bit 1 overflow: signed overflow for add and subtract, product outside the signed 16-bit range for multiply, zero divisor for divide, 0 otherwise. Bit 2 negative: `result[15]`. Bit 3 zero: `result` equals 0. Bit 5 less-than: signed first operand below second operand.
- R8: With `flag_we` low, bits 0 to 3 and bit 5 keep their values. Bits 7 and 6 always read 0.
- R9: With `cmp_mode` high, the operation is forced to subtract whatever `op_code` is. `result_we` is 0 and the accumulators do not change.
- R10: Status bit 4 (interrupt enable) is cleared by `ie_clr` and set by `ie_set`, with clear taking priority. `flag_we` never changes it.
- R11: `br_taken` is combinational from the registered flags: `br_kind` 0 gives zero, 1 gives not-zero, 2 gives less-than, and 3 gives neither less-than nor zero.
- R12: After reset, `status`, `acc_hi` and `acc_lo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_reg | input | 16 | A register value |
| b_reg | input | 16 | B register value |
| mdr | input | 16 | Memory data register value |
| pc | input | 16 | Program counter |
| ir_imm | input | 9 | Instruction register bits 8..0 |
| sel_a | input | 2 | First operand select |
| sel_b | input | 2 | Second operand select |
| op_code | input | 3 | Operation code |
| cmp_mode | input | 1 | Compare: force subtract, no register write |
| issue | input | 1 | Operation issued this cycle (enables accumulator load and result write) |
| flag_we | input | 1 | Arithmetic flag write enable |
| ie_set | input | 1 | Set interrupt enable |
| ie_clr | input | 1 | Clear interrupt enable |
| br_kind | input | 2 | Branch condition select |
| result | output | 16 | Single-word result |
| result_we | output | 1 | Result should be written to the destination register |
| acc_hi | output | 16 | Accumulator high |
| acc_lo | output | 16 | Accumulator low |
| status | output | 8 | Status register |
| br_taken | output | 1 | Selected branch condition holds |

## Verification
A wrong flag register shows on `status` one cycle after the edge that loaded it. It also shows at once on `br_taken` for any branch kind that reads the bad bit. A corrupted accumulator is visible on `acc_hi`/`acc_lo` from the next cycle and stays there until the next issued multiply or divide. That matters most for a divide by zero, which must leave the previous product in place. Operand-select or operation faults show in the same cycle on `result` and `result_we`. A fault in the compare path shows up as an accumulator change or a write request where none is allowed.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_NOR = 3'd4,
    OP_SLT = 3'd5,
    OP_MUL = 3'd6,
    OP_DIV = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SA_AREG = 2'd0,
    SA_MDR  = 2'd1,
    SA_PC   = 2'd2,
    SA_ZERO = 2'd3
  } src_a_e;

  typedef enum logic [1:0] {
    SB_BREG = 2'd0,
    SB_MDR  = 2'd1,
    SB_TWO  = 2'd2,
    SB_IMM  = 2'd3
  } src_b_e;

  typedef enum logic [1:0] {
    BR_EQ = 2'd0,
    BR_NE = 2'd1,
    BR_LT = 2'd2,
    BR_GT = 2'd3
  } br_kind_e;

  localparam int SR_W  = 8;
  localparam int FL_C  = 0;
  localparam int FL_O  = 1;
  localparam int FL_N  = 2;
  localparam int FL_Z  = 3;
  localparam int FL_IE = 4;
  localparam int FL_LT = 5;

  typedef struct packed {
    logic c;
    logic o;
    logic n;
    logic z;
    logic l;
  } flags_t;

endpackage

// File: rtl/alu16_opsel.sv
module alu16_opsel
  import alu16_pkg::*;
#(
  parameter int W     = 16,
  parameter int IMM_W = 9
) (
  input  logic [W-1:0]     a_reg,
  input  logic [W-1:0]     b_reg,
  input  logic [W-1:0]     mdr,
  input  logic [W-1:0]     pc,
  input  logic [IMM_W-1:0] imm,
  input  src_a_e           sel_a,
  input  src_b_e           sel_b,
  output logic [W-1:0]     opa,
  output logic [W-1:0]     opb
);

  localparam logic [W-1:0] CONST_TWO = W'(2);

  logic [W-1:0] imm_ext;

  generate
    if (IMM_W >= W) begin : g_imm_trim
      assign imm_ext = imm[W-1:0];
    end else begin : g_imm_zext
      assign imm_ext = {{(W-IMM_W){1'b0}}, imm};
    end
  endgenerate

  always_comb begin
    unique case (sel_a)
      SA_AREG: opa = a_reg;
      SA_MDR:  opa = mdr;
      SA_PC:   opa = pc;
      default: opa = '0;
    endcase
  end

  always_comb begin
    unique case (sel_b)
      SB_BREG: opb = b_reg;
      SB_MDR:  opb = mdr;
      SB_TWO:  opb = CONST_TWO;
      default: opb = imm_ext;
    endcase
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         fl_c,
  output logic         fl_o,
  output logic         fl_l,
  output logic [W-1:0] wide_hi,
  output logic [W-1:0] wide_lo,
  output logic         wide_ld
);

  localparam int PW = 2 * W;

  logic [W:0]    sum;
  logic [W:0]    diff;
  logic [PW-1:0] prod;
  logic [W-1:0]  quo;
  logic [W-1:0]  rem;
  logic          div_zero;
  logic          slt;
  logic          prod_ovf;

  assign sum      = {1'b0, opa} + {1'b0, opb};
  assign diff     = {1'b0, opa} - {1'b0, opb};
  assign prod     = $signed({{W{opa[W-1]}}, opa}) * $signed({{W{opb[W-1]}}, opb});
  assign div_zero = (opb == '0);
  assign slt      = ($signed(opa) < $signed(opb));
  assign prod_ovf = (|prod[PW-1:W-1]) & ~(&prod[PW-1:W-1]);

  always_comb begin
    if (div_zero) begin
      quo = '0;
      rem = '0;
    end else begin
      quo = $signed(opa) / $signed(opb);
      rem = $signed(opa) % $signed(opb);
    end
  end

  always_comb begin
    res     = '0;
    fl_c    = 1'b0;
    fl_o    = 1'b0;
    wide_hi = '0;
    wide_lo = '0;
    wide_ld = 1'b0;
    unique case (op)
      OP_ADD: begin
        res  = sum[W-1:0];
        fl_c = sum[W];
        fl_o = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
      end
      OP_SUB: begin
        res  = diff[W-1:0];
        fl_c = diff[W];
        fl_o = (opa[W-1] != opb[W-1]) && (diff[W-1] != opa[W-1]);
      end
      OP_AND: res = opa & opb;
      OP_OR:  res = opa | opb;
      OP_NOR: res = ~(opa | opb);
      OP_SLT: res = {{(W-1){1'b0}}, slt};
      OP_MUL: begin
        res     = prod[W-1:0];
        fl_o    = prod_ovf;
        wide_hi = prod[PW-1:W];
        wide_lo = prod[W-1:0];
        wide_ld = 1'b1;
      end
      default: begin
        res     = quo;
        fl_o    = div_zero;
        wide_hi = rem;
        wide_lo = quo;
        wide_ld = ~div_zero;
      end
    endcase
  end

  assign fl_l = slt;

endmodule

// File: rtl/alu16_accum.sv
module alu16_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);

  logic [W-1:0] hi_d;
  logic [W-1:0] lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (ld) begin
      hi_d = hi_in;
      lo_d = lo_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable({hi_q, lo_q}));  // R6

  AST_ACC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (hi_q == $past(hi_in)) && (lo_q == $past(lo_in)));  // R4

endmodule

// File: rtl/alu16_status.sv
module alu16_status
  import alu16_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flag_we,
  input  flags_t          fl_in,
  input  logic            ie_set,
  input  logic            ie_clr,
  input  br_kind_e        br_kind,
  output logic [SR_W-1:0] sr,
  output logic            br_taken
);

  flags_t fl_q, fl_d;
  logic   ie_q, ie_d;

  always_comb begin
    fl_d = fl_q;
    if (flag_we) fl_d = fl_in;
  end

  always_comb begin
    ie_d = ie_q;
    if (ie_clr)      ie_d = 1'b0;
    else if (ie_set) ie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q <= '0;
      ie_q <= 1'b0;
    end else begin
      fl_q <= fl_d;
      ie_q <= ie_d;
    end
  end

  always_comb begin
    sr        = '0;
    sr[FL_C]  = fl_q.c;
    sr[FL_O]  = fl_q.o;
    sr[FL_N]  = fl_q.n;
    sr[FL_Z]  = fl_q.z;
    sr[FL_IE] = ie_q;
    sr[FL_LT] = fl_q.l;
  end

  always_comb begin
    unique case (br_kind)
      BR_EQ:   br_taken = fl_q.z;
      BR_NE:   br_taken = ~fl_q.z;
      BR_LT:   br_taken = fl_q.l;
      default: br_taken = ~fl_q.l & ~fl_q.z;
    endcase
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable({sr[FL_LT], sr[FL_Z:FL_C]}));  // R8

  AST_IE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_set && !ie_clr) |=> sr[FL_IE]);  // R10

  AST_IE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr |=> !sr[FL_IE]);  // R10

  AST_IE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_set && !ie_clr) |=> $stable(sr[FL_IE]));  // R10

endmodule

// File: rtl/alu16_mc.sv
module alu16_mc
  import alu16_pkg::*;
#(
  parameter int W     = 16,
  parameter int IMM_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    a_reg,
  input  logic [W-1:0]    b_reg,
  input  logic [W-1:0]    mdr,
  input  logic [W-1:0]    pc,
  input  logic [IMM_W-1:0] ir_imm,
  input  logic [1:0]      sel_a,
  input  logic [1:0]      sel_b,
  input  logic [2:0]      op_code,
  input  logic            cmp_mode,
  input  logic            issue,
  input  logic            flag_we,
  input  logic            ie_set,
  input  logic            ie_clr,
  input  logic [1:0]      br_kind,
  output logic [W-1:0]    result,
  output logic            result_we,
  output logic [W-1:0]    acc_hi,
  output logic [W-1:0]    acc_lo,
  output logic [SR_W-1:0] status,
  output logic            br_taken
);

  logic [1:0]   rst_sync;
  logic         rst_int_n;
  logic [W-1:0] opa, opb;
  alu_op_e      op_eff;
  logic         c_fl, o_fl, l_fl;
  logic [W-1:0] wide_hi, wide_lo;
  logic         wide_ld;
  logic         acc_ld;
  logic         wide_op;
  flags_t       fl_new;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign op_eff  = cmp_mode ? OP_SUB : alu_op_e'(op_code);
  assign wide_op = (op_code == OP_MUL) || (op_code == OP_DIV);

  alu16_opsel #(.W(W), .IMM_W(IMM_W)) i_opsel (
    .a_reg (a_reg),
    .b_reg (b_reg),
    .mdr   (mdr),
    .pc    (pc),
    .imm   (ir_imm),
    .sel_a (src_a_e'(sel_a)),
    .sel_b (src_b_e'(sel_b)),
    .opa   (opa),
    .opb   (opb)
  );

  alu16_core #(.W(W)) i_core (
    .opa     (opa),
    .opb     (opb),
    .op      (op_eff),
    .res     (result),
    .fl_c    (c_fl),
    .fl_o    (o_fl),
    .fl_l    (l_fl),
    .wide_hi (wide_hi),
    .wide_lo (wide_lo),
    .wide_ld (wide_ld)
  );

  assign acc_ld    = issue & wide_ld;
  assign result_we = issue & ~cmp_mode & ~wide_op;

  alu16_accum #(.W(W)) i_accum (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ld    (acc_ld),
    .hi_in (wide_hi),
    .lo_in (wide_lo),
    .hi_q  (acc_hi),
    .lo_q  (acc_lo)
  );

  always_comb begin
    fl_new.c = c_fl;
    fl_new.o = o_fl;
    fl_new.n = result[W-1];
    fl_new.z = (result == '0);
    fl_new.l = l_fl;
  end

  alu16_status i_status (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .flag_we  (flag_we),
    .fl_in    (fl_new),
    .ie_set   (ie_set),
    .ie_clr   (ie_clr),
    .br_kind  (br_kind_e'(br_kind)),
    .sr       (status),
    .br_taken (br_taken)
  );

  AST_DIV0_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_code == OP_DIV && !cmp_mode && opb == '0) |=> $stable({acc_hi, acc_lo}));  // R5

  AST_CMP_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmp_mode |=> $stable({acc_hi, acc_lo}));  // R9

  AST_DIV0_OVF: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_we && op_code == OP_DIV && !cmp_mode && opb == '0) |=> status[FL_O]);  // R5

endmodule

// File: tb/test_alu16_mc.sv
module test_alu16_mc;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] a_reg, b_reg, mdr, pc;
  logic [8:0]  ir_imm;
  logic [1:0]  sel_a, sel_b, br_kind;
  logic [2:0]  op_code;
  logic        cmp_mode, issue, flag_we, ie_set, ie_clr;
  logic [15:0] result, acc_hi, acc_lo;
  logic        result_we, br_taken;
  logic [7:0]  status;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0]  exp_sr;
  logic [15:0] exp_hi, exp_lo;

  always #5 clk = ~clk;

  alu16_mc i_alu16_mc (
    .clk(clk), .rst_n(rst_n), .a_reg(a_reg), .b_reg(b_reg), .mdr(mdr), .pc(pc),
    .ir_imm(ir_imm), .sel_a(sel_a), .sel_b(sel_b), .op_code(op_code),
    .cmp_mode(cmp_mode), .issue(issue), .flag_we(flag_we), .ie_set(ie_set),
    .ie_clr(ie_clr), .br_kind(br_kind), .result(result), .result_we(result_we),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .status(status), .br_taken(br_taken)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic cmp,
                                input logic [15:0] a, input logic [15:0] b,
                                output logic [15:0] res, output logic c,
                                output logic o, output logic l,
                                output logic accw, output logic [15:0] hi,
                                output logic [15:0] lo);
    logic [2:0]  eop;
    logic [16:0] s;
    logic [31:0] p;
    eop = cmp ? 3'd1 : op;
    c = 0; o = 0; accw = 0; hi = 0; lo = 0; res = 0;
    l = ($signed(a) < $signed(b));
    case (eop)
      3'd0: begin s = a + b; res = s[15:0]; c = s[16];
                  o = (a[15] == b[15]) && (res[15] != a[15]); end
      3'd1: begin res = a - b; c = (a < b);
                  o = (a[15] != b[15]) && (res[15] != a[15]); end
      3'd2: res = a & b;
      3'd3: res = a | b;
      3'd4: res = ~(a | b);
      3'd5: res = {15'd0, l};
      3'd6: begin
        p = 32'($signed(a) * $signed(b));
        p = $signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b});
        res = p[15:0]; hi = p[31:16]; lo = p[15:0]; accw = 1;
        o = ($signed(p) > 32'sd32767) || ($signed(p) < -32'sd32768);
      end
      default: begin
        if (b == 0) begin res = 0; o = 1; end
        else begin
          res = $signed(a) / $signed(b);
          hi  = $signed(a) % $signed(b);
          lo  = res; accw = 1;
        end
      end
    endcase
  endfunction

  task automatic run_step();
    logic [15:0] oa, ob, res, hi, lo;
    logic c, o, l, accw, exp_br, exp_we;
    string tag;
    #1;
    case (sel_a)
      2'd0: oa = a_reg; 2'd1: oa = mdr; 2'd2: oa = pc; default: oa = 16'd0;
    endcase
    case (sel_b)
      2'd0: ob = b_reg; 2'd1: ob = mdr; 2'd2: ob = 16'd2; default: ob = {7'd0, ir_imm};
    endcase
    model(op_code, cmp_mode, oa, ob, res, c, o, l, accw, hi, lo);
    if (cmp_mode)              tag = "R9";
    else if (op_code == 3'd6)  tag = "R4";
    else if (op_code == 3'd7)  tag = "R5";
    else if (sel_a != 2'd0)    tag = "R2";
    else if (sel_b != 2'd0)    tag = "R3";
    else                       tag = "R1";
    chk({tag, " result"}, 32'(result), 32'(res));
    exp_we = issue && !cmp_mode && (op_code < 3'd6);
    chk({tag, " result_we"}, 32'(result_we), 32'(exp_we));
    case (br_kind)
      2'd0: exp_br = exp_sr[3];
      2'd1: exp_br = !exp_sr[3];
      2'd2: exp_br = exp_sr[5];
      default: exp_br = !exp_sr[5] && !exp_sr[3];
    endcase
    chk("R11 br_taken", 32'(br_taken), 32'(exp_br));
    if (flag_we) begin
      exp_sr[0] = c; exp_sr[1] = o; exp_sr[2] = res[15];
      exp_sr[3] = (res == 16'd0); exp_sr[5] = l;
    end
    if (ie_clr) exp_sr[4] = 0; else if (ie_set) exp_sr[4] = 1;
    if (issue && accw) begin exp_hi = hi; exp_lo = lo; end
    @(posedge clk);
    @(negedge clk);
    chk(flag_we ? "R7 status" : "R8 status", 32'(status), 32'(exp_sr));
    chk("R10 ie", 32'(status[4]), 32'(exp_sr[4]));
    if (issue && accw && !cmp_mode) tag = (op_code == 3'd7) ? "R5" : "R4";
    else                            tag = "R6";
    chk({tag, " acc"}, {acc_hi, acc_lo}, {exp_hi, exp_lo});
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] sa, input logic [1:0] sb,
                       input logic [15:0] a, input logic [15:0] b, input logic cmp,
                       input logic iss, input logic fwe, input logic [1:0] bk);
    op_code = op; sel_a = sa; sel_b = sb; a_reg = a; b_reg = b;
    cmp_mode = cmp; issue = iss; flag_we = fwe; br_kind = bk;
    ie_set = 0; ie_clr = 0;
    run_step();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; a_reg = 0; b_reg = 0; mdr = 16'h1234; pc = 16'h0100; ir_imm = 9'h1FF;
    sel_a = 0; sel_b = 0; op_code = 0; cmp_mode = 0; issue = 0; flag_we = 0;
    ie_set = 0; ie_clr = 0; br_kind = 0;
    exp_sr = 0; exp_hi = 0; exp_lo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R12 status", 32'(status), 32'd0);
    chk("R12 acc", {acc_hi, acc_lo}, 32'd0);

    // directed corners
    drive(3'd0, 2'd0, 2'd0, 16'h7FFF, 16'h0001, 0, 1, 1, 2'd0);   // R7 add overflow
    drive(3'd1, 2'd0, 2'd0, 16'h0003, 16'h0005, 0, 1, 1, 2'd2);   // R7 borrow
    drive(3'd6, 2'd0, 2'd0, 16'h8000, 16'h8000, 0, 1, 1, 2'd2);   // R4
    drive(3'd7, 2'd0, 2'd0, 16'hFFF9, 16'h0002, 0, 1, 1, 2'd1);   // R5 -7/2
    drive(3'd7, 2'd0, 2'd0, 16'h0009, 16'h0000, 0, 1, 1, 2'd0);   // R5 divide by zero
    drive(3'd0, 2'd2, 2'd2, 16'h0000, 16'h0000, 0, 1, 0, 2'd3);   // R2 R3 pc+2
    drive(3'd3, 2'd3, 2'd3, 16'hFFFF, 16'hFFFF, 0, 1, 1, 2'd0);   // R2 R3 zero|imm
    drive(3'd6, 2'd0, 2'd0, 16'h0005, 16'h0005, 1, 1, 1, 2'd0);   // R9 compare equal
    drive(3'd0, 2'd0, 2'd0, 16'h0001, 16'h0001, 0, 0, 0, 2'd0);   // R11 eq after compare
    drive(3'd1, 2'd0, 2'd0, 16'hFFFE, 16'h0001, 1, 1, 1, 2'd3);   // R9 -2 vs 1
    drive(3'd5, 2'd0, 2'd0, 16'h0000, 16'h0000, 0, 0, 0, 2'd2);   // R11 lt
    drive(3'd5, 2'd0, 2'd0, 16'h0009, 16'h0003, 1, 0, 1, 2'd3);   // R9 9 vs 3
    drive(3'd2, 2'd0, 2'd0, 16'h0000, 16'h0000, 0, 0, 0, 2'd3);   // R11 gt
    ie_set = 1; ie_clr = 0; run_step();                            // R10 set
    ie_set = 1; ie_clr = 1; flag_we = 1; run_step();               // R10 clear wins
    ie_set = 1; ie_clr = 0; run_step();
    ie_set = 0; flag_we = 1; op_code = 3'd4; run_step();           // R10 flag_we keeps ie

    for (int i = 0; i < 600; i++) begin
      op_code  = 3'($urandom % 8);
      sel_a    = 2'($urandom % 4);
      sel_b    = 2'($urandom % 4);
      a_reg    = 16'($urandom);
      b_reg    = ($urandom % 12 == 0) ? 16'd0 : 16'($urandom);
      mdr      = ($urandom % 12 == 0) ? 16'd0 : 16'($urandom);
      pc       = 16'($urandom);
      ir_imm   = 9'($urandom);
      cmp_mode = ($urandom % 6 == 0);
      issue    = ($urandom % 4 != 0);
      flag_we  = ($urandom % 2 == 0);
      ie_set   = ($urandom % 6 == 0);
      ie_clr   = ($urandom % 6 == 0);
      br_kind  = 2'($urandom % 4);
      run_step();
    end

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule